// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Grid

This block is a square grid of DIM by DIM multiply-accumulate cells (DIM is 8 by default) that forms one matrix product per pass. A weight matrix is first shifted in from the top edge. While a load-enable input is high, the whole set of weights moves down one row per clock. When the enable is low, every cell keeps its weight. The rows of the data matrix then enter at the left edge, one lane per grid row, and step one column to the right on every clock.

Each column's running sum starts from a value supplied on a per-column seed input at the top. The sum moves down one row per clock, and every cell on the way adds the product of its data operand and its held weight. The bottom row of the grid drives the per-column results. The caller provides the diagonal skew: element k of data row i must be presented on lane k exactly k clocks after element 0 of that row. No FIFOs or output realignment are part of the block.

Top module: `smx_array`

## Requirements
- R1: If element k of data row i is presented on lane k, to be taken at clock edge T+i+k, then column c of the result shows seed[c] plus the sum over k of A[i][k]*W[k][c] immediately after edge T+i+c+DIM-1.
- R2: Holding the load enable high for DIM consecutive edges leaves grid row r with the weight vector that was presented on the edge numbered DIM-1-r, counting from 0. The first vector in therefore ends at the bottom row.
- R3: While the load enable is low, every cell keeps its weight and the top weight inputs have no effect on any result.
- R4: A data operand taken by a cell at one edge is used by the cell one column to the right at the next edge. Grid row k uses lane k only.
- R5: Each cell registers the incoming partial sum plus its signed product, so a sum moves down exactly one row per clock. The top row adds to the per-column seed input.
- R6: Each operand lane carries a two's-complement 8-bit value in bits [7:0]. Bits [15:8] of every data and weight lane are ignored.
- R7: Products are sign-extended to 32 bits, and the sums wrap modulo 2^32.
- R8: While rst_n is sampled low at a clock edge, all data, weight and sum registers clear to zero. Results read zero after that edge, and until new weights are loaded each column returns only its seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| w_en | input | 1 | Weight load enable; shifts weights down one row per clock while high |
| w_top | input | DIM*16 | Weight vector entering the top row, one 16-bit lane per column |
| a_left | input | DIM*16 | Data operands entering the left column, one 16-bit lane per grid row |
| init_sum | input | DIM*32 | Per-column seed added at the top of each column |
| col_sum | output | DIM*32 | Per-column results from the bottom row |

## Verification
The hardest case to reach from the ports is one where a weight row lands in the wrong grid row, or a data operand reaches a cell one clock early or late. Such a fault still produces plausible numbers. It shows only when every row of the weight matrix and every skew offset gives a different contribution. The stimulus therefore uses weight and data matrices with distinct values per row and column. It includes sign extremes and drives junk on the upper lane bytes and on the idle weight inputs. A scoreboard predicts each column result at the exact clock on which it must appear. A final pass after a mid-run reset shows that the cleared weights leave only the seeds.

// File: rtl/smx_pkg.sv
package smx_pkg;
    parameter int SMX_DIM  = 8;
    parameter int SMX_OPW  = 16;
    parameter int SMX_ELW  = 8;
    parameter int SMX_SUMW = 32;
endpackage

// File: rtl/smx_pe.sv
module smx_pe #(
    parameter int ELW  = smx_pkg::SMX_ELW,
    parameter int SUMW = smx_pkg::SMX_SUMW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            w_en,
    input  logic [ELW-1:0]  w_in,
    input  logic [ELW-1:0]  a_in,
    input  logic [SUMW-1:0] s_in,
    output logic [ELW-1:0]  w_out,
    output logic [ELW-1:0]  a_out,
    output logic [SUMW-1:0] s_out
);
    localparam int PW = 2 * ELW;
    localparam int XW = SUMW - PW;

    logic [ELW-1:0]        w_q;
    logic [ELW-1:0]        a_q;
    logic [SUMW-1:0]       s_q;
    logic signed [PW-1:0]  a_x;
    logic signed [PW-1:0]  w_x;
    logic signed [PW-1:0]  prod;
    logic [SUMW-1:0]       prod_x;

    // signed operands widened before the multiply
    assign a_x    = $signed({{ELW{a_in[ELW-1]}}, a_in});
    assign w_x    = $signed({{ELW{w_q[ELW-1]}}, w_q});
    assign prod   = a_x * w_x;
    assign prod_x = {{XW{prod[PW-1]}}, prod};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
            a_q <= '0;
            s_q <= '0;
        end else begin
            a_q <= a_in;
            s_q <= s_in + prod_x;
            if (w_en) begin
                w_q <= w_in;
            end
        end
    end

    assign w_out = w_q;
    assign a_out = a_q;
    assign s_out = s_q;

    AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !w_en |=> $stable(w_out));                                   // R3
    AST_W_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        w_en |=> (w_out == $past(w_in)));                            // R2
    AST_ZERO_A_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (a_in == '0) |=> (s_out == $past(s_in)));                    // R5
    AST_ZERO_W_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (w_out == '0) |=> (s_out == $past(s_in)));                   // R5
    AST_RST_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (w_out == '0 && a_out == '0 && s_out == '0));     // R8
endmodule

// File: rtl/smx_column.sv
module smx_column #(
    parameter int DIM  = smx_pkg::SMX_DIM,
    parameter int ELW  = smx_pkg::SMX_ELW,
    parameter int SUMW = smx_pkg::SMX_SUMW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     w_en,
    input  logic [ELW-1:0]           w_top,
    input  logic [SUMW-1:0]          seed,
    input  logic [DIM-1:0][ELW-1:0]  a_in,
    output logic [DIM-1:0][ELW-1:0]  a_out,
    output logic [SUMW-1:0]          s_bot
);
    logic [DIM:0][ELW-1:0]  w_chain;
    logic [DIM:0][SUMW-1:0] s_chain;
    logic                   unused_wtail;

    assign w_chain[0] = w_top;
    assign s_chain[0] = seed;

    for (genvar r = 0; r < DIM; r++) begin : g_row
        smx_pe #(
            .ELW (ELW),
            .SUMW(SUMW)
        ) u_pe (
            .clk  (clk),
            .rst_n(rst_n),
            .w_en (w_en),
            .w_in (w_chain[r]),
            .a_in (a_in[r]),
            .s_in (s_chain[r]),
            .w_out(w_chain[r+1]),
            .a_out(a_out[r]),
            .s_out(s_chain[r+1])
        );
    end

    assign s_bot        = s_chain[DIM];
    assign unused_wtail = ^w_chain[DIM];
endmodule

// File: rtl/smx_array.sv
module smx_array #(
    parameter int DIM  = smx_pkg::SMX_DIM,
    parameter int OPW  = smx_pkg::SMX_OPW,
    parameter int ELW  = smx_pkg::SMX_ELW,
    parameter int SUMW = smx_pkg::SMX_SUMW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     w_en,
    input  logic [DIM-1:0][OPW-1:0]  w_top,
    input  logic [DIM-1:0][OPW-1:0]  a_left,
    input  logic [DIM-1:0][SUMW-1:0] init_sum,
    output logic [DIM-1:0][SUMW-1:0] col_sum
);
    logic [DIM:0][DIM-1:0][ELW-1:0] a_chain;
    logic                           unused_fold;

    // only the low byte of every lane is an operand
    for (genvar r = 0; r < DIM; r++) begin : g_lane
        assign a_chain[0][r] = a_left[r][ELW-1:0];
    end

    for (genvar c = 0; c < DIM; c++) begin : g_col
        smx_column #(
            .DIM (DIM),
            .ELW (ELW),
            .SUMW(SUMW)
        ) u_col (
            .clk  (clk),
            .rst_n(rst_n),
            .w_en (w_en),
            .w_top(w_top[c][ELW-1:0]),
            .seed (init_sum[c]),
            .a_in (a_chain[c]),
            .a_out(a_chain[c+1]),
            .s_bot(col_sum[c])
        );
    end

    always_comb begin
        unused_fold = ^a_chain[DIM];
        for (int r = 0; r < DIM; r++) begin
            unused_fold = unused_fold ^ (^w_top[r][OPW-1:ELW]) ^ (^a_left[r][OPW-1:ELW]);
        end
    end

    AST_RST_OUT_ZERO: assert property (@(posedge clk)
        !rst_n |=> (col_sum == '0));                                  // R8
endmodule

// File: tb/tb_smx_array.sv
module tb_smx_array;
    localparam int N    = 8;
    localparam int OPW  = 16;
    localparam int SUMW = 32;

    typedef struct {
        int          due;
        int          col;
        int          row;
        logic [31:0] val;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                     rst_n = 1'b0;
    logic                     w_en = 1'b0;
    logic [N-1:0][OPW-1:0]    w_top = '0;
    logic [N-1:0][OPW-1:0]    a_left = '0;
    logic [N-1:0][SUMW-1:0]   init_sum = '0;
    logic [N-1:0][SUMW-1:0]   col_sum;

    smx_array dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .w_en    (w_en),
        .w_top   (w_top),
        .a_left  (a_left),
        .init_sum(init_sum),
        .col_sum (col_sum)
    );

    int ecnt = 0;
    always @(posedge clk) ecnt <= ecnt + 1;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    int   amat [0:15][0:N-1];
    int   bmat [0:N-1][0:N-1];
    exp_t sb[$];
    exp_t keep_q[$];

    task automatic check(input string tag, input int col, input int row,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s col=%0d row=%0d actual=%h expected=%h", tag, col, row, got, exp);
        end
    endtask

    // monitor: compare every result due in this cycle
    always @(negedge clk) begin
        keep_q = {};
        foreach (sb[k]) begin
            if (sb[k].due == ecnt) check(sb[k].tag, sb[k].col, sb[k].row, col_sum[sb[k].col], sb[k].val);
            else keep_q.push_back(sb[k]);
        end
        sb = keep_q;
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        w_en = 1'b0;
        a_left = '0;
        w_top = '0;
        repeat (2) @(negedge clk);
        for (int c = 0; c < N; c++) check("R8 reset clears", c, -1, col_sum[c], 32'h0);
        for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) bmat[r][c] = 0;
        rst_n = 1'b1;
    endtask

    task automatic load_weights(input bit hi_junk);
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            w_en = 1'b1;
            for (int c = 0; c < N; c++)
                w_top[c] = {(hi_junk ? 8'(k * 29 + c * 11 + 3) : 8'h00), 8'(bmat[N-1-k][c])};
        end
        @(negedge clk);
        w_en = 1'b0;
        for (int c = 0; c < N; c++) w_top[c] = 16'(16'h5A3C + c * 97);
    endtask

    // driver: push expected items, then feed the skewed rows
    task automatic run_batch(input int m, input bit hi_junk, input string tag);
        int es;
        @(negedge clk);
        es = ecnt;
        for (int i = 0; i < m; i++) begin
            for (int c = 0; c < N; c++) begin
                exp_t e;
                logic [31:0] acc;
                acc = init_sum[c];
                for (int r = 0; r < N; r++) acc = acc + 32'(amat[i][r] * bmat[r][c]);
                e.due = es + i + c + N;
                e.col = c;
                e.row = i;
                e.val = acc;
                e.tag = tag;
                sb.push_back(e);
            end
        end
        for (int t = 0; t < m + N; t++) begin
            if (t > 0) @(negedge clk);
            for (int r = 0; r < N; r++) begin
                int i;
                i = t - r;
                a_left[r] = {(hi_junk ? 8'(t * 13 + r * 7 + 1) : 8'h00),
                             ((i >= 0 && i < m) ? 8'(amat[i][r]) : 8'h00)};
                w_top[r] = 16'(t * 4099 + r * 613);
            end
        end
        repeat (m + 2 * N + 2) @(negedge clk);
        a_left = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1 R2 R4 R5: distinct weights per cell, zero seeds
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                bmat[r][c] = ((r * 37 + c * 11 + 5) % 256) - 128;
        bmat[0][0] = -128;
        bmat[N-1][N-1] = 127;
        load_weights(1'b0);
        for (int i = 0; i < 16; i++)
            for (int r = 0; r < N; r++)
                amat[i][r] = ((i * 23 + r * 59 + 17) % 256) - 128;
        init_sum = '0;
        run_batch(8, 1'b0, "R1 R2 R4 R5 product");

        // R3 R5 R6: seeds, junk upper bytes, junk on idle weight inputs
        for (int c = 0; c < N; c++) init_sum[c] = 32'(c * 100003 - 400000);
        run_batch(12, 1'b1, "R3 R5 R6 seeded");

        // R7 R6: sign extremes and wrap
        for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) bmat[r][c] = -128;
        load_weights(1'b1);
        for (int i = 0; i < 3; i++) for (int r = 0; r < N; r++) amat[i][r] = -128;
        for (int c = 0; c < N; c++) init_sum[c] = 32'h7FFF0000;
        run_batch(3, 1'b1, "R7 wrap");

        // R8: mid-run reset drops weights, only seeds remain
        do_reset();
        for (int i = 0; i < 4; i++) for (int r = 0; r < N; r++) amat[i][r] = 50 - i * 30 + r;
        for (int c = 0; c < N; c++) init_sum[c] = 32'(c * 7 + 12345);
        run_batch(4, 1'b0, "R8 weights cleared");

        foreach (sb[k]) begin
            n_chk++;
            n_bad++;
            $display("FAIL %s col=%0d row=%0d actual=missing expected=%h", sb[k].tag, sb[k].col, sb[k].row, sb[k].val);
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule